// File: doc/BRIEF.md
# Perceptron Write-Push Coherence Predictor

This block sits beside a directory and decides, on each write to a tracked shared block, whether the writer should keep the line in Modified state (NO-PUSH) or be demoted to Shared with its dirty data forwarded to readers (PUSH). The decision rests on a small single-layer perceptron per tracked entry. The perceptron has one signed weight per bit of that entry's access history and no bias term. It predicts PUSH when the weighted sum is strictly positive.

Each write leaves its prediction pending on the entry. The next access to the same entry settles the pending prediction. A read from a node other than the writer means the data was consumed. Any write means it was not. A read by the writer itself leaves the question open. When the settled label disagrees with the prediction, the weights of that entry take one additive learning step in the following cycle. Picking consumers, moving data and running the coherence state machine all lie outside this block. It only raises a push request and a downgrade request next to the decision.

Top module: `pwp_write_push_predictor`

## Requirements
- R1: After reset no decision is presented, and every weight is zero, so the first write to any entry is decided NO-PUSH.
- R2: Each access with the write flag set produces exactly one decision in the next cycle, carrying that access's entry index and writer node. A read produces no decision.
- R3: The decision is PUSH exactly when the sum over history positions of (+w if the bit is 1, -w if the bit is 0) is greater than zero. A sum of zero or below gives NO-PUSH.
- R4: Every access to an entry shifts its history left by one and places 1 (write) or 0 (read) in bit 0. A write is predicted from the history as it stood before that write.
- R5: A pending prediction is settled CONSUMED by a read from a node other than the last writer and NOT-CONSUMED by any write. A read from the last writer leaves it pending.
- R6: Weights change only when the settled label differs from the stored prediction. Weight i then moves by +1 when the label (CONSUMED=1) equals history bit i of the history snapshot taken at prediction, and by -1 otherwise. The step is applied at the end of the cycle after settlement.
- R7: Weights are WEIGHT_W-bit two's complement and stop at their most positive and most negative values instead of wrapping.
- R8: When a learning step and a write to the same entry fall in the same cycle, that write is predicted with the stepped weights.
- R9: push_req and downgrade_req are both high exactly in a decision cycle whose decision is PUSH.
- R10: Accesses and learning steps on one entry leave every other entry's history, pending state and weights untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access to a tracked entry is present |
| acc_is_write | input | 1 | 1 for a write, 0 for a read |
| acc_block | input | IDX_W | Tracked entry index |
| acc_node | input | NODE_W | Requesting node |
| dec_valid | output | 1 | A decision for last cycle's write is presented |
| dec_push | output | 1 | 1 = PUSH, 0 = NO-PUSH |
| dec_block | output | IDX_W | Entry the decision belongs to |
| dec_writer | output | NODE_W | Writer the decision belongs to |
| push_req | output | 1 | Request to forward the dirty data |
| downgrade_req | output | 1 | Request to demote the writer to Shared |

## Verification
The bench drives a long pseudo-random access stream over a reduced configuration with narrow weights, so clamping at both limits happens often. It checks every decision against an arithmetic model. The corner cases it targets are a write that lands in the same cycle as its own entry's learning step (a design that reads stale weights gives a wrong decision), a read by the writer itself (a design that settles on it trains wrongly and drifts), a weight at a limit (a wrapping design flips the sign of a sum), and an exactly-zero sum (a design using "not negative" pushes). Entries with all-zero weights confirm the reset state and the NO-PUSH tie rule.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  typedef enum logic {
    LBL_NOT_CONSUMED = 1'b0,
    LBL_CONSUMED     = 1'b1
  } pwp_label_e;

endpackage

// File: rtl/pwp_weight_bank.sv
module pwp_weight_bank
  import pwp_pkg::*;
#(
  parameter int N_ENT    = 16,
  parameter int HIST_LEN = 8,
  parameter int WEIGHT_W = 6,
  parameter int IDX_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         train_valid,
  input  logic [IDX_W-1:0]             train_idx,
  input  pwp_label_e                   train_label,
  input  logic [HIST_LEN-1:0]          train_hist,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [HIST_LEN*WEIGHT_W-1:0] rd_weights
);

  localparam int MAXW = (2 ** (WEIGHT_W - 1)) - 1;
  localparam int MINW = -(2 ** (WEIGHT_W - 1));

  logic [WEIGHT_W-1:0] w_q   [N_ENT][HIST_LEN];
  logic [WEIGHT_W-1:0] upd_row [HIST_LEN];

  // Next-state: one saturating learning step on the row being trained
  for (genvar i = 0; i < HIST_LEN; i++) begin : g_step
    always_comb begin
      int cur;
      int nxt;
      cur = int'($signed(w_q[train_idx][i]));
      if ((train_label == LBL_CONSUMED) == train_hist[i]) nxt = cur + 1;
      else                                                nxt = cur - 1;
      if (nxt > MAXW) nxt = MAXW;
      if (nxt < MINW) nxt = MINW;
      upd_row[i] = nxt[WEIGHT_W-1:0];
    end

    // Read port forwards a same-cycle step on the same row
    assign rd_weights[i*WEIGHT_W +: WEIGHT_W] =
      (train_valid && (train_idx == rd_idx)) ? upd_row[i] : w_q[rd_idx][i];
  end

  // Register process with explicit row enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++)
        for (int i = 0; i < HIST_LEN; i++)
          w_q[e][i] <= '0;
    end else if (train_valid) begin
      for (int i = 0; i < HIST_LEN; i++)
        w_q[train_idx][i] <= upd_row[i];
    end
  end

  for (genvar i = 0; i < HIST_LEN; i++) begin : g_chk
    // R6: one learning step moves a weight by at most one
    a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      train_valid |=>
        ((int'($signed(w_q[$past(train_idx)][i])) - int'($past($signed(w_q[train_idx][i])))) <= 1) &&
        ((int'($signed(w_q[$past(train_idx)][i])) - int'($past($signed(w_q[train_idx][i])))) >= -1));
    // R7: a weight at the top limit never wraps to the bottom
    a_r7_no_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (train_valid && (int'($signed(w_q[train_idx][i])) == MAXW)) |=>
        (int'($signed(w_q[$past(train_idx)][i])) >= MAXW - 1));
    // R7: a weight at the bottom limit never wraps to the top
    a_r7_no_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (train_valid && (int'($signed(w_q[train_idx][i])) == MINW)) |=>
        (int'($signed(w_q[$past(train_idx)][i])) <= MINW + 1));
  end

endmodule

// File: rtl/pwp_dot.sv
module pwp_dot #(
  parameter int HIST_LEN = 8,
  parameter int WEIGHT_W = 6
) (
  input  logic [HIST_LEN-1:0]          hist,
  input  logic [HIST_LEN*WEIGHT_W-1:0] weights,
  output logic                         push
);

  localparam int SUM_W = WEIGHT_W + $clog2(HIST_LEN) + 2;

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    logic signed [SUM_W-1:0] term;
    acc = '0;
    for (int i = 0; i < HIST_LEN; i++) begin
      term = SUM_W'($signed(weights[i*WEIGHT_W +: WEIGHT_W]));
      if (hist[i]) acc = acc + term;
      else         acc = acc - term;
    end
    push = (acc > 0);
  end

endmodule

// File: rtl/pwp_tracker.sv
module pwp_tracker
  import pwp_pkg::*;
#(
  parameter int N_ENT    = 16,
  parameter int HIST_LEN = 8,
  parameter int NODE_W   = 4,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_is_write,
  input  logic [IDX_W-1:0]    acc_block,
  input  logic [NODE_W-1:0]   acc_node,
  input  logic                new_pred,
  output logic [HIST_LEN-1:0] cur_hist,
  output logic                train_valid,
  output logic [IDX_W-1:0]    train_idx,
  output pwp_label_e          train_label,
  output logic [HIST_LEN-1:0] train_hist
);

  logic [HIST_LEN-1:0] hist_q  [N_ENT];
  logic [HIST_LEN-1:0] snap_q  [N_ENT];
  logic [NODE_W-1:0]   owner_q [N_ENT];
  logic [N_ENT-1:0]    pend_q;
  logic [N_ENT-1:0]    pred_q;

  logic                settle;
  pwp_label_e          label;
  logic                mispred;
  logic [HIST_LEN-1:0] hist_nx;
  logic                pend_nx;

  assign cur_hist = hist_q[acc_block];

  // Next-state logic for the addressed entry
  always_comb begin
    settle  = acc_valid && pend_q[acc_block] &&
              (acc_is_write || (acc_node != owner_q[acc_block]));
    label   = acc_is_write ? LBL_NOT_CONSUMED : LBL_CONSUMED;
    mispred = settle && (pred_q[acc_block] != (label == LBL_CONSUMED));
    hist_nx = {hist_q[acc_block][HIST_LEN-2:0], acc_is_write};
    if (acc_is_write) pend_nx = 1'b1;
    else if (settle)  pend_nx = 1'b0;
    else              pend_nx = pend_q[acc_block];
  end

  // Entry state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        hist_q[e]  <= '0;
        snap_q[e]  <= '0;
        owner_q[e] <= '0;
      end
      pend_q <= '0;
      pred_q <= '0;
    end else if (acc_valid) begin
      hist_q[acc_block] <= hist_nx;
      pend_q[acc_block] <= pend_nx;
      if (acc_is_write) begin
        pred_q[acc_block]  <= new_pred;
        snap_q[acc_block]  <= hist_q[acc_block];
        owner_q[acc_block] <= acc_node;
      end
    end
  end

  // Learning request register, one cycle after settlement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      train_valid <= 1'b0;
      train_idx   <= '0;
      train_label <= LBL_NOT_CONSUMED;
      train_hist  <= '0;
    end else begin
      train_valid <= mispred;
      if (mispred) begin
        train_idx   <= acc_block;
        train_label <= label;
        train_hist  <= snap_q[acc_block];
      end
    end
  end

  // R4: newest history bit records the access kind
  a_r4_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (hist_q[$past(acc_block)][0] == $past(acc_is_write)));
  // R5: a read by the last writer leaves the prediction pending
  a_r5_own_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_is_write && pend_q[acc_block] && (acc_node == owner_q[acc_block]))
      |=> pend_q[$past(acc_block)]);
  // R5: a remote read closes the pending prediction
  a_r5_remote_read_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_is_write && (acc_node != owner_q[acc_block]))
      |=> !pend_q[$past(acc_block)]);
  // R6: no learning request without a settled prediction the cycle before
  a_r6_train_needs_settle: assert property (@(posedge clk) disable iff (!rst_n)
    train_valid |-> $past(acc_valid && pend_q[acc_block]));

endmodule

// File: rtl/pwp_write_push_predictor.sv
module pwp_write_push_predictor
  import pwp_pkg::*;
#(
  parameter int N_ENT    = 16,
  parameter int HIST_LEN = 8,
  parameter int WEIGHT_W = 6,
  parameter int NODE_W   = 4,
  localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_write,
  input  logic [IDX_W-1:0]  acc_block,
  input  logic [NODE_W-1:0] acc_node,
  output logic              dec_valid,
  output logic              dec_push,
  output logic [IDX_W-1:0]  dec_block,
  output logic [NODE_W-1:0] dec_writer,
  output logic              push_req,
  output logic              downgrade_req
);

  logic [HIST_LEN-1:0]          cur_hist;
  logic [HIST_LEN*WEIGHT_W-1:0] cur_weights;
  logic                         pred_push;
  logic                         train_valid;
  logic [IDX_W-1:0]             train_idx;
  pwp_label_e                   train_label;
  logic [HIST_LEN-1:0]          train_hist;
  logic                         wr_now;

  assign wr_now = acc_valid && acc_is_write;

  pwp_tracker #(
    .N_ENT(N_ENT), .HIST_LEN(HIST_LEN), .NODE_W(NODE_W), .IDX_W(IDX_W)
  ) u_tracker (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_is_write(acc_is_write),
    .acc_block(acc_block), .acc_node(acc_node),
    .new_pred(pred_push), .cur_hist(cur_hist),
    .train_valid(train_valid), .train_idx(train_idx),
    .train_label(train_label), .train_hist(train_hist)
  );

  pwp_weight_bank #(
    .N_ENT(N_ENT), .HIST_LEN(HIST_LEN), .WEIGHT_W(WEIGHT_W), .IDX_W(IDX_W)
  ) u_weights (
    .clk(clk), .rst_n(rst_n),
    .train_valid(train_valid), .train_idx(train_idx),
    .train_label(train_label), .train_hist(train_hist),
    .rd_idx(acc_block), .rd_weights(cur_weights)
  );

  pwp_dot #(
    .HIST_LEN(HIST_LEN), .WEIGHT_W(WEIGHT_W)
  ) u_dot (
    .hist(cur_hist), .weights(cur_weights), .push(pred_push)
  );

  // Decision register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_push   <= 1'b0;
      dec_block  <= '0;
      dec_writer <= '0;
    end else begin
      dec_valid <= wr_now;
      if (wr_now) begin
        dec_push   <= pred_push;
        dec_block  <= acc_block;
        dec_writer <= acc_node;
      end
    end
  end

  assign push_req      = dec_valid && dec_push;
  assign downgrade_req = dec_valid && dec_push;

  // R2: every write yields a decision next cycle
  a_r2_write_decides: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> (dec_valid && (dec_block == $past(acc_block)) && (dec_writer == $past(acc_node))));
  // R2: no decision without a write
  a_r2_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_now |=> !dec_valid);
  // R1: an entry never trained since reset cannot be pushed
  a_r1_zero_state_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && (cur_weights == '0)) |=> !push_req);

endmodule

// File: tb/tb_pwp_write_push_predictor.sv
`timescale 1ns/1ps
module tb_pwp_write_push_predictor;

  localparam int NE = 4;
  localparam int HL = 4;
  localparam int WW = 3;
  localparam int NW = 2;
  localparam int IW = 2;
  localparam int WMAX = 3;
  localparam int WMIN = -4;
  localparam int NSTEPS = 30000;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_is_write;
  logic [IW-1:0] acc_block;
  logic [NW-1:0] acc_node;
  logic dec_valid, dec_push, push_req, downgrade_req;
  logic [IW-1:0] dec_block;
  logic [NW-1:0] dec_writer;

  always #2 clk = ~clk;

  pwp_write_push_predictor #(
    .N_ENT(NE), .HIST_LEN(HL), .WEIGHT_W(WW), .NODE_W(NW)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_is_write(acc_is_write),
    .acc_block(acc_block), .acc_node(acc_node),
    .dec_valid(dec_valid), .dec_push(dec_push),
    .dec_block(dec_block), .dec_writer(dec_writer),
    .push_req(push_req), .downgrade_req(downgrade_req)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arithmetic model state
  int m_hist [NE];
  int m_w    [NE][HL];
  bit m_pend [NE];
  bit m_pred [NE];
  int m_snap [NE];
  int m_own  [NE];
  bit m_sat  [NE];
  bit m_ownrd[NE];
  bit tr_v;
  int tr_idx, tr_lab, tr_snap;

  bit e_valid, e_push, e_same, e_zero, e_sat, e_own;
  int e_blk, e_wr, e_sum;
  int cnt_r5 = 0, cnt_r7 = 0, cnt_r8 = 0, cnt_push = 0, cnt_tie = 0;
  bit done = 1'b0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  function automatic void model_step(bit v, bit wr, int idx, int node);
    bit same;
    bit settle;
    int lab;
    same = tr_v && (tr_idx == idx) && v && wr;
    if (tr_v) begin
      for (int i = 0; i < HL; i++) begin
        int nw;
        nw = m_w[tr_idx][i] + ((tr_lab == ((tr_snap >> i) & 1)) ? 1 : -1);
        if (nw > WMAX) begin nw = WMAX; m_sat[tr_idx] = 1'b1; end
        if (nw < WMIN) begin nw = WMIN; m_sat[tr_idx] = 1'b1; end
        m_w[tr_idx][i] = nw;
      end
    end
    tr_v = 1'b0;
    e_valid = v && wr;
    if (e_valid) begin
      e_sum = 0;
      e_zero = 1'b1;
      for (int i = 0; i < HL; i++) begin
        if (m_w[idx][i] != 0) e_zero = 1'b0;
        e_sum += ((m_hist[idx] >> i) & 1) ? m_w[idx][i] : -m_w[idx][i];
      end
      e_push = (e_sum > 0);
      e_blk = idx; e_wr = node; e_same = same;
      e_sat = m_sat[idx]; e_own = m_ownrd[idx];
      m_sat[idx] = 1'b0; m_ownrd[idx] = 1'b0;
    end
    if (v) begin
      settle = m_pend[idx] && (wr || (node != m_own[idx]));
      if (!wr && m_pend[idx] && node == m_own[idx]) m_ownrd[idx] = 1'b1;
      lab = wr ? 0 : 1;
      if (settle && (int'(m_pred[idx]) != lab)) begin
        tr_v = 1'b1; tr_idx = idx; tr_lab = lab; tr_snap = m_snap[idx];
      end
      if (wr) begin
        m_pend[idx] = 1'b1; m_pred[idx] = e_push;
        m_snap[idx] = m_hist[idx]; m_own[idx] = node;
      end else if (settle) begin
        m_pend[idx] = 1'b0;
      end
      m_hist[idx] = ((m_hist[idx] << 1) | int'(wr)) & ((1 << HL) - 1);
    end
  endfunction

  task automatic check_outputs();
    string tg;
    chk(dec_valid == e_valid, "R2 decision presence", int'(dec_valid), int'(e_valid));
    chk(push_req == (e_valid && e_push), "R9 push_req", int'(push_req), int'(e_valid && e_push));
    chk(downgrade_req == (e_valid && e_push), "R9 downgrade_req", int'(downgrade_req), int'(e_valid && e_push));
    if (e_valid) begin
      chk(dec_block == IW'(e_blk), "R2 block", int'(dec_block), e_blk);
      chk(dec_writer == NW'(e_wr), "R2 writer", int'(dec_writer), e_wr);
      tg = "R3 R4 R6 R10";
      if (e_zero) tg = {tg, " R1"};
      if (e_same) begin tg = {tg, " R8"}; cnt_r8++; end
      if (e_sat)  begin tg = {tg, " R7"}; cnt_r7++; end
      if (e_own)  begin tg = {tg, " R5"}; cnt_r5++; end
      if (e_push) cnt_push++;
      if (e_sum == 0 && !e_zero) cnt_tie++;
      chk(dec_push == e_push, tg, int'(dec_push), int'(e_push));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned r;
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_is_write = 1'b0; acc_block = '0; acc_node = '0;
    for (int e = 0; e < NE; e++) begin
      m_hist[e] = 0; m_pend[e] = 0; m_pred[e] = 0; m_snap[e] = 0;
      m_own[e] = 0; m_sat[e] = 0; m_ownrd[e] = 0;
      for (int i = 0; i < HL; i++) m_w[e][i] = 0;
    end
    tr_v = 0; tr_idx = 0; tr_lab = 0; tr_snap = 0; e_valid = 0; e_push = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dec_valid == 1'b0, "R1 reset dec_valid", int'(dec_valid), 0);
    chk(push_req == 1'b0, "R1 reset push_req", int'(push_req), 0);
    chk(downgrade_req == 1'b0, "R1 reset downgrade_req", int'(downgrade_req), 0);
    rst_n = 1'b1;
    r = 32'h1234_5678;
    for (int s = 0; s < NSTEPS; s++) begin
      bit v, wr;
      int idx, node;
      @(negedge clk);
      if (s > 0) check_outputs();
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      v = (r[1:0] != 2'b00);
      wr = r[2];
      idx = int'(r[4:3]);
      node = int'(r[6:5]);
      if (s % 4000 < 40) idx = 0;
      acc_valid = v; acc_is_write = wr;
      acc_block = IW'(idx); acc_node = NW'(node);
      model_step(v, wr, idx, node);
    end
    @(negedge clk);
    check_outputs();
    acc_valid = 1'b0;
    chk(cnt_r5 > 0, "R5 own-read case exercised", cnt_r5, 1);
    chk(cnt_r7 > 0, "R7 saturation exercised", cnt_r7, 1);
    chk(cnt_r8 > 0, "R8 same-cycle step exercised", cnt_r8, 1);
    chk(cnt_push > 0, "R3 push decisions seen", cnt_push, 1);
    chk(cnt_tie > 0, "R3 zero-sum tie seen", cnt_tie, 1);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule